// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Detection

This block turns a serial line into parallel characters. The line is first brought into the receive clock domain. The block then waits for a falling edge and checks that edge at mid-bit, so that a short glitch does not count as a start bit. It then takes eight data bits, least significant first, and one stop bit, sampling each at the centre of its bit cell. The length of a bit cell is set by an oversampling factor of 1, 16 or 64 receive clocks, chosen on a select input.

A finished character is placed in an output register and a ready flag is raised. The host clears the flag with a read strobe. If another character finishes while the flag is still up, the new character replaces the old one and a sticky overrun flag is set. A low stop bit sets a sticky framing flag, and the character is still delivered. A separate error-clear pulse clears both sticky flags.

A break output rises once two characters in a row have ended with a low stop bit. It falls as soon as the synchronised line is high again.

Top module: `serial_char_rx`

## Requirements
- R1: After the synchronous active-high reset, `rx_data` is 0 and `rx_ready`, `rx_overrun`, `rx_frame_err` and `rx_break` are all 0. The line synchroniser resets to the idle (high) level.
- R2: `baud_sel` sets the bit-cell length in clocks: 0 selects 1, 1 selects 16, and 2 or 3 select 64.
- R3: A low level on the synchronised line starts a character only if the line is still low half a bit cell later (factor/2 clocks; no wait at factor 1). If the line is high at that point, the receiver goes back to idle and delivers nothing.
- R4: Each character is one start bit, eight data bits sent LSB first and one stop bit, sampled one full bit cell apart. In the clock after the stop-bit sample, the byte appears on `rx_data` and `rx_ready` is 1.
- R5: A cycle with `rd_stb` high clears `rx_ready`. If a character completes in the same cycle, `rx_ready` stays 1.
- R6: If a character completes while `rx_ready` is 1 and `rd_stb` is low, the new byte replaces the old one and `rx_overrun` becomes 1. `rx_overrun` stays 1 until a cycle with `err_clr` high, unless a new overrun is set in that same cycle.
- R7: A stop bit sampled low sets `rx_frame_err` and the character is still delivered. `rx_frame_err` is sticky and is cleared by `err_clr`.
- R8: `rx_break` becomes 1 in the clock after the second of two consecutive characters whose stop bits were sampled low.
- R9: `rx_break` returns to 0 in the clock after the synchronised line is high. A character with a high stop bit restarts the count of low stop bits.
- R10: While `rx_en` is 0 the receiver stays idle and ignores the line. Any character in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| baud_sel | input | 2 | Oversampling factor select (0: x1, 1: x16, 2/3: x64) |
| rxd | input | 1 | Serial input line, idle high |
| rd_stb | input | 1 | Host read strobe, clears ready |
| err_clr | input | 1 | Clears the overrun and framing flags |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | A character is waiting to be read |
| rx_overrun | output | 1 | A character was lost (sticky) |
| rx_frame_err | output | 1 | A stop bit was sampled low (sticky) |
| rx_break | output | 1 | Line held at space through two stop bits in a row |

## Verification
The assertions assume that `baud_sel` changes only while the receiver is idle and that `err_clr` is never pulsed in the same cycle as a completing character. The stimulus meets both assumptions: it changes the factor only between characters after long idle gaps, and it pulses `rd_stb` and `err_clr` only while the line is idle. Characters are sent at exactly the selected bit-cell length, one full cell per bit. Break runs are made by holding the line low for many bit cells, and glitches by holding it low for fewer clocks than half a cell.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxb_framer.sv
module rxb_framer
  import rxb_pkg::*;
#(
  parameter int DW       = 8,
  parameter int FAC_MID  = 16,
  parameter int FAC_HIGH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          line,
  input  logic [1:0]    sel,
  output logic          done,
  output logic          stop_bit,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(FAC_HIGH) + 1;
  localparam int BW = $clog2(DW) + 1;

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   fac_m1;
  logic [CW-1:0]   half;
  logic [BW-1:0]   bits;
  logic [DW-1:0]   sh;

  always_comb begin
    case (sel)
      2'd0:    begin fac_m1 = '0;                half = '0; end
      2'd1:    begin fac_m1 = CW'(FAC_MID - 1);  half = CW'(FAC_MID / 2); end
      default: begin fac_m1 = CW'(FAC_HIGH - 1); half = CW'(FAC_HIGH / 2); end
    endcase
  end

  assign done     = en && (state == ST_STOP) && (cnt == fac_m1);
  assign stop_bit = line;
  assign data     = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bits  <= '0;
      sh    <= '0;
    end else if (!en) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt  <= '0;
          bits <= '0;
          if (!line) begin
            if (half == '0) state <= ST_DATA;
            else begin
              state <= ST_START;
              cnt   <= CW'(1);
            end
          end
        end
        ST_START: begin
          if (cnt == half) begin
            cnt <= '0;
            if (line) state <= ST_IDLE;
            else      state <= ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == fac_m1) begin
            cnt  <= '0;
            sh   <= {line, sh[DW-1:1]};
            bits <= bits + 1'b1;
            if (bits == BW'(DW - 1)) state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == fac_m1) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R10: disabled receiver returns to idle
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> state == ST_IDLE);
  // R3: line high at the mid-bit check rejects the start
  p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_START && cnt == half && line) |=> state == ST_IDLE);
  // R4: completion only follows a data phase
  p_stop_after_data_r4: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_STOP && $past(state) != ST_STOP) |-> $past(state) == ST_DATA);
endmodule

// File: rtl/rxb_host.sv
module rxb_host #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic          stop_bit,
  input  logic [DW-1:0] din,
  input  logic          rd,
  input  logic          err_clr,
  output logic [DW-1:0] data,
  output logic          ready,
  output logic          ovr,
  output logic          fe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      ready <= 1'b0;
      ovr   <= 1'b0;
      fe    <= 1'b0;
    end else begin
      if (err_clr) begin
        ovr <= 1'b0;
        fe  <= 1'b0;
      end
      if (done) begin
        data  <= din;
        ready <= 1'b1;
        if (ready && !rd) ovr <= 1'b1;
        if (!stop_bit)    fe  <= 1'b1;
      end else if (rd) begin
        ready <= 1'b0;
      end
    end
  end

  p_ready_set_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> ready);
  p_ready_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && !done) |=> !ready);
  p_ovr_set_r6: assert property (@(posedge clk) disable iff (rst)
    (done && ready && !rd) |=> ovr);
  p_ovr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ovr && !err_clr) |=> ovr);
  p_fe_set_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !stop_bit) |=> (fe && ready));
endmodule

// File: rtl/rxb_break.sv
module rxb_break #(
  parameter int RUN_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic done,
  input  logic stop_bit,
  output logic brk
);
  localparam int RW = $clog2(RUN_LEN + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
      brk <= 1'b0;
    end else if (line) begin
      run <= '0;
      brk <= 1'b0;
    end else if (done) begin
      if (!stop_bit) begin
        if (run < RW'(RUN_LEN)) run <= run + 1'b1;
        if (run >= RW'(RUN_LEN - 1)) brk <= 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  p_brk_clear_r9: assert property (@(posedge clk) disable iff (rst)
    line |=> !brk);
  p_brk_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(brk) |-> $past(done && !stop_bit));
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int DW          = 8,
  parameter int FAC_MID     = 16,
  parameter int FAC_HIGH    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int BREAK_RUN   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [1:0]    baud_sel,
  input  logic          rxd,
  input  logic          rd_stb,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rx_overrun,
  output logic          rx_frame_err,
  output logic          rx_break
);
  logic          line_s;
  logic          done;
  logic          stop_bit;
  logic [DW-1:0] shreg;

  rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  rxb_framer #(.DW(DW), .FAC_MID(FAC_MID), .FAC_HIGH(FAC_HIGH)) u_framer (
    .clk(clk), .rst(rst), .en(rx_en), .line(line_s), .sel(baud_sel),
    .done(done), .stop_bit(stop_bit), .data(shreg)
  );

  rxb_host #(.DW(DW)) u_host (
    .clk(clk), .rst(rst), .done(done), .stop_bit(stop_bit), .din(shreg),
    .rd(rd_stb), .err_clr(err_clr), .data(rx_data), .ready(rx_ready),
    .ovr(rx_overrun), .fe(rx_frame_err)
  );

  rxb_break #(.RUN_LEN(BREAK_RUN)) u_break (
    .clk(clk), .rst(rst), .line(line_s), .done(done), .stop_bit(stop_bit),
    .brk(rx_break)
  );
endmodule

// File: tb/serial_char_rx_tb.sv
`timescale 1ns/1ps
module serial_char_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] baud_sel = 2'd1;
  logic       rxd = 1'b1;
  logic       rd_stb = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_overrun, rx_frame_err, rx_break;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_on = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  serial_char_rx u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .baud_sel(baud_sel), .rxd(rxd),
    .rd_stb(rd_stb), .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  // behavioural reference: time since start detection decides every sample
  logic       m_s1, m_s2;
  bit         m_busy;
  int         m_t, m_run;
  logic [7:0] m_sh, e_data;
  logic       e_ready, e_ovr, e_fe, e_brk;

  function automatic int fac_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 16 : 64;
  endfunction

  always @(posedge clk) begin
    logic ln;
    logic stop_ev;
    logic stopv;
    int fac, half, k;
    ln = m_s2;
    stop_ev = 1'b0;
    stopv = 1'b1;
    fac = fac_of(baud_sel);
    half = fac / 2;
    if (rst) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_busy = 0; m_t = 0; m_run = 0; m_sh = '0;
      e_data = '0; e_ready = 0; e_ovr = 0; e_fe = 0; e_brk = 0;
    end else begin
      if (!rx_en) m_busy = 0;
      else if (!m_busy) begin
        if (!ln) begin m_busy = 1; m_t = 0; end
      end else begin
        m_t++;
        if (half > 0 && m_t == half && ln) m_busy = 0;
        else if (m_t > half && ((m_t - half) % fac) == 0) begin
          k = (m_t - half) / fac;
          if (k <= 8) m_sh[k-1] = ln;
          else begin stop_ev = 1'b1; stopv = ln; m_busy = 0; end
        end
      end
      if (err_clr) begin e_ovr = 0; e_fe = 0; end
      if (stop_ev) begin
        if (e_ready && !rd_stb) e_ovr = 1;
        e_ready = 1; e_data = m_sh;
        if (!stopv) e_fe = 1;
      end else if (rd_stb) e_ready = 0;
      if (ln) begin e_brk = 0; m_run = 0; end
      else if (stop_ev) begin
        if (!stopv) begin
          if (m_run < 2) m_run++;
          if (m_run >= 2) e_brk = 1;
        end else m_run = 0;
      end
      m_s2 = m_s1; m_s1 = rxd;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk(rx_data, e_data, "R4 model rx_data");
      chk({7'd0, rx_ready}, {7'd0, e_ready}, "R5 model rx_ready");
      chk({7'd0, rx_overrun}, {7'd0, e_ovr}, "R6 model rx_overrun");
      chk({7'd0, rx_frame_err}, {7'd0, e_fe}, "R7 model rx_frame_err");
      chk({7'd0, rx_break}, {7'd0, e_brk}, "R8 model rx_break");
    end
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog act=%0d exp=<200000", cyc);
      report();
    end
  end

  task automatic cells(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic stopb);
    int f;
    f = fac_of(baud_sel);
    cells(1'b0, f);
    for (int i = 0; i < 8; i++) cells(c[i], f);
    cells(stopb, f);
    cells(1'b1, 3 * f + 6);
  endtask

  task automatic pulse_rd;
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr;
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    // R1: reset state
    chk(rx_data, 8'h00, "R1 rx_data after reset");
    chk({4'd0, rx_ready, rx_overrun, rx_frame_err, rx_break}, 8'h00, "R1 flags after reset");

    // R2/R4: x16
    baud_sel = 2'd1; send(8'hA5, 1'b1);
    chk(rx_data, 8'hA5, "R4 byte LSB first x16");
    chk({7'd0, rx_ready}, 8'h01, "R4 ready after char");
    pulse_rd;
    chk({7'd0, rx_ready}, 8'h00, "R5 ready cleared by read");

    // R2: x1 and x64
    baud_sel = 2'd0; send(8'h3C, 1'b1);
    chk(rx_data, 8'h3C, "R2 byte at factor 1");
    pulse_rd;
    baud_sel = 2'd2; send(8'h81, 1'b1);
    chk(rx_data, 8'h81, "R2 byte at factor 64");
    pulse_rd;
    baud_sel = 2'd3; send(8'h6E, 1'b1);
    chk(rx_data, 8'h6E, "R2 select 3 acts as 64");
    pulse_rd;

    // R3: glitch shorter than half a cell
    baud_sel = 2'd1;
    cells(1'b0, 4); cells(1'b1, 200);
    chk({7'd0, rx_ready}, 8'h00, "R3 false start rejected");
    chk(rx_data, 8'h6E, "R3 data unchanged by glitch");

    // R6: overrun
    send(8'h11, 1'b1); send(8'h22, 1'b1);
    chk({7'd0, rx_overrun}, 8'h01, "R6 overrun set");
    chk(rx_data, 8'h22, "R6 newer byte kept");
    cells(1'b1, 10);
    chk({7'd0, rx_overrun}, 8'h01, "R6 overrun sticky");
    pulse_clr; pulse_rd;
    chk({7'd0, rx_overrun}, 8'h00, "R6 overrun cleared");

    // R7: framing error
    send(8'h5A, 1'b0);
    chk(rx_data, 8'h5A, "R7 byte delivered with bad stop");
    chk({7'd0, rx_frame_err}, 8'h01, "R7 frame error set");
    chk({7'd0, rx_break}, 8'h00, "R9 one low stop is no break");
    pulse_clr; pulse_rd;
    chk({7'd0, rx_frame_err}, 8'h00, "R7 frame error cleared");

    // R8/R9: break
    cells(1'b0, 16 * 25);
    chk({7'd0, rx_break}, 8'h01, "R8 break after two low stops");
    cells(1'b1, 6);
    chk({7'd0, rx_break}, 8'h00, "R9 break cleared on high line");
    cells(1'b1, 100);
    pulse_clr; pulse_rd;

    // R10: disabled receiver
    rx_en = 1'b0; send(8'hC3, 1'b1);
    chk({7'd0, rx_ready}, 8'h00, "R10 no char while disabled");
    rx_en = 1'b1; send(8'h96, 1'b1);
    chk(rx_data, 8'h96, "R10 receives after enable");
    pulse_rd;

    repeat (5) @(negedge clk);
    done_flag = 1;
    report();
  end
endmodule